// File: doc/BRIEF.md
# Power-Switchover Timestamp Capture

This block records the calendar time at the two moments when the supply source changes. When the power-source indicator shows a move from main power to the backup battery, the packed BCD time/date word from the clock is stored in a to-battery snapshot bank. When the indicator shows a return to main power, the same word is stored in a separate to-main snapshot bank. Each bank is five bytes wide.

The two banks follow opposite retention rules. The to-battery bank keeps the first outage it sees and ignores later ones until the host empties it. The to-main bank is overwritten on every return, so it always shows the latest recovery. A small register port lets the host read any snapshot byte and clear bytes. Writing 00h clears one byte. A control bit clears the whole to-battery bank at once. The indicator is asynchronous to the block clock, so it is synchronized first, and captures fire only on its edges.

Top module: `pwr_ts_capture`

## Requirements
- R1: A change of `on_batt` from 0 to 1 stores `time_now` into `bat_snap` on the third rising clock edge after the change: two synchronizer stages, then the capture register. `bat_snap` is unchanged after the second edge.
- R2: A change of `on_batt` from 1 to 0 stores `time_now` into `main_snap` with the same three-edge latency.
- R3: When `bat_snap` is not empty, later to-battery events leave it unchanged.
- R4: Every to-main event overwrites `main_snap` with the current `time_now`.
- R5: A write of 00h to address k clears one byte. Addresses 0 to 4 select `bat_snap` bits [8k+7:8k]. Addresses 5 to 9 select `main_snap` bits [8(k-5)+7:8(k-5)]. A write of any nonzero value to these addresses has no effect.
- R6: A write to address 10 with bit 0 set clears all of `bat_snap` in that cycle and leaves `main_snap` unchanged.
- R7: A bank counts as empty only when all five of its bytes are 00h. `bat_valid` and `main_valid` are high exactly when the matching bank is not empty. A to-battery event captures only into an empty bank.
- R8: A steady level on `on_batt` causes no capture. While the level holds, a snapshot stays fixed even when `time_now` changes.
- R9: When a capture and a byte clear or bank clear hit the same bank in the same cycle, the captured value is stored.
- R10: `rd_data` returns the byte selected by `rd_addr` one clock after the address is presented. It uses the byte map of R5. Address 10 and the unused addresses 11 to 15 read 00h.
- R11: After reset both banks are zero, both valid flags are low and `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| on_batt | input | 1 | Power-source indicator, asynchronous; 1 means running from the battery |
| time_now | input | 40 | Packed BCD time/date from the clock counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data |
| bat_snap | output | 40 | To-battery snapshot bank |
| bat_valid | output | 1 | To-battery bank holds a snapshot |
| main_snap | output | 40 | To-main snapshot bank |
| main_valid | output | 1 | To-main bank holds a snapshot |

## Verification
An emptiness test that is wrong in the to-battery bank shows up as a changed or unchanged `bat_snap` on the third edge after the next outage. This also holds for a partly cleared bank that is wrongly treated as empty. The same applies to a wrong retention rule. A synchronizer or edge detector that is off by a stage moves the capture by one edge, or repeats it while the level holds. Either fault becomes visible on the snapshot ports within a few cycles of the indicator change. Clear decoding faults appear on the snapshot bytes in the cycle after the write and on `rd_data` one cycle after the read address.

// File: rtl/pwr_ts_pkg.sv
package pwr_ts_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CLR_BIT = 0;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_BATT = 1'b1
  } power_src_e;
endpackage

// File: rtl/pwr_ts_sync.sv
module pwr_ts_sync
  import pwr_ts_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_async,
  output logic to_bat_evt,
  output logic to_main_evt
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= SRC_MAIN;
          else     chain_q[0] <= src_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= SRC_MAIN;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= SRC_MAIN;
    else     prev_q <= chain_q[LAST];
  end

  assign to_bat_evt  = (chain_q[LAST] == SRC_BATT) && (prev_q == SRC_MAIN);
  assign to_main_evt = (chain_q[LAST] == SRC_MAIN) && (prev_q == SRC_BATT);
endmodule

// File: rtl/pwr_ts_bank.sv
module pwr_ts_bank
  import pwr_ts_pkg::*;
#(
  parameter int unsigned BYTES      = 5,
  parameter bit          KEEP_FIRST = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap,
  input  logic [BYTES*BYTE_W-1:0] time_in,
  input  logic [BYTES-1:0]        byte_clr,
  input  logic                    all_clr,
  output logic [BYTES*BYTE_W-1:0] snap,
  output logic                    valid
);
  logic empty;
  logic do_cap;

  assign empty = (snap == '0);

  generate
    if (KEEP_FIRST) begin : g_first
      assign do_cap = cap && empty;
    end else begin : g_latest
      assign do_cap = cap;
    end
  endgenerate

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)                          snap[b*BYTE_W +: BYTE_W] <= '0;
        else if (do_cap)                  snap[b*BYTE_W +: BYTE_W] <= time_in[b*BYTE_W +: BYTE_W];
        else if (all_clr || byte_clr[b])  snap[b*BYTE_W +: BYTE_W] <= '0;
      end
    end
  endgenerate

  assign valid = !empty;
endmodule

// File: rtl/pwr_ts_regif.sv
module pwr_ts_regif
  import pwr_ts_pkg::*;
#(
  parameter int unsigned BYTES  = 5,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [BYTES*BYTE_W-1:0] bat_snap,
  input  logic [BYTES*BYTE_W-1:0] main_snap,
  output logic [BYTES-1:0]        bat_byte_clr,
  output logic [BYTES-1:0]        main_byte_clr,
  output logic                    bat_all_clr,
  output logic [BYTE_W-1:0]       rd_data
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * BYTES);

  logic              zero_wr;
  logic [BYTE_W-1:0] rd_next;

  assign zero_wr = wr_en && (wr_data == '0);

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_clr
      assign bat_byte_clr[b]  = zero_wr && (wr_addr == ADDR_W'(b));
      assign main_byte_clr[b] = zero_wr && (wr_addr == ADDR_W'(BYTES + b));
    end
  endgenerate

  assign bat_all_clr = wr_en && (wr_addr == CTRL_ADDR) && wr_data[CLR_BIT];

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (rd_addr == ADDR_W'(b))         rd_next = bat_snap[b*BYTE_W +: BYTE_W];
      if (rd_addr == ADDR_W'(BYTES + b)) rd_next = main_snap[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pwr_ts_capture.sv
module pwr_ts_capture
  import pwr_ts_pkg::*;
#(
  parameter int unsigned TS_BYTES    = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4,
  localparam int unsigned TS_W       = TS_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              on_batt,
  input  logic [TS_W-1:0]   time_now,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [TS_W-1:0]   bat_snap,
  output logic              bat_valid,
  output logic [TS_W-1:0]   main_snap,
  output logic              main_valid
);
  logic                to_bat_evt;
  logic                to_main_evt;
  logic [TS_BYTES-1:0] bat_byte_clr;
  logic [TS_BYTES-1:0] main_byte_clr;
  logic                bat_all_clr;

  pwr_ts_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst        (rst),
    .src_async  (on_batt),
    .to_bat_evt (to_bat_evt),
    .to_main_evt(to_main_evt)
  );

  pwr_ts_regif #(.BYTES(TS_BYTES), .ADDR_W(ADDR_W)) regif_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .bat_snap     (bat_snap),
    .main_snap    (main_snap),
    .bat_byte_clr (bat_byte_clr),
    .main_byte_clr(main_byte_clr),
    .bat_all_clr  (bat_all_clr),
    .rd_data      (rd_data)
  );

  pwr_ts_bank #(.BYTES(TS_BYTES), .KEEP_FIRST(1'b1)) bat_bank_i (
    .clk     (clk),
    .rst     (rst),
    .cap     (to_bat_evt),
    .time_in (time_now),
    .byte_clr(bat_byte_clr),
    .all_clr (bat_all_clr),
    .snap    (bat_snap),
    .valid   (bat_valid)
  );

  pwr_ts_bank #(.BYTES(TS_BYTES), .KEEP_FIRST(1'b0)) main_bank_i (
    .clk     (clk),
    .rst     (rst),
    .cap     (to_main_evt),
    .time_in (time_now),
    .byte_clr(main_byte_clr),
    .all_clr (1'b0),
    .snap    (main_snap),
    .valid   (main_valid)
  );
endmodule

// File: rtl/pwr_ts_chk.sv
module pwr_ts_chk #(
  parameter int unsigned TS_W = 40
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [TS_W-1:0] time_now,
  input logic [TS_W-1:0] bat_snap,
  input logic            bat_valid,
  input logic [TS_W-1:0] main_snap,
  input logic            to_bat_evt,
  input logic            to_main_evt
);
  AST_BAT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (to_bat_evt && !bat_valid) |=> (bat_snap == $past(time_now))); // R1

  AST_MAIN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    to_main_evt |=> (main_snap == $past(time_now))); // R4

  AST_BAT_KEEP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (bat_valid && !wr_en) |=> $stable(bat_snap)); // R3

  AST_MAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !to_main_evt) |=> $stable(main_snap)); // R8

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({to_bat_evt, to_main_evt})); // R8
endmodule

bind pwr_ts_capture pwr_ts_chk #(.TS_W(TS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .time_now   (time_now),
  .bat_snap   (bat_snap),
  .bat_valid  (bat_valid),
  .main_snap  (main_snap),
  .to_bat_evt (to_bat_evt),
  .to_main_evt(to_main_evt)
);

// File: tb/pwr_ts_capture_tb.sv
`timescale 1ns/1ps
module pwr_ts_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        on_batt = 1'b0;
  logic [39:0] time_now = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [39:0] bat_snap;
  logic        bat_valid;
  logic [39:0] main_snap;
  logic        main_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_ts_capture dut_i (
    .clk(clk), .rst(rst), .on_batt(on_batt), .time_now(time_now),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .bat_snap(bat_snap), .bat_valid(bat_valid),
    .main_snap(main_snap), .main_valid(main_valid)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_power(input logic v, input logic [39:0] t);
    @(negedge clk);
    time_now = t;
    on_batt  = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 bat_snap", bat_snap, '0);
    chk("R11 main_snap", main_snap, '0);
    chk("R11 valids", {38'd0, bat_valid, main_valid}, '0);
    chk("R11 rd_data", {32'd0, rd_data}, '0);
    reg_rd(4'd3, d);
    chk("R11 read byte", {32'd0, d}, '0);
  endtask

  task automatic t_first_capture();
    logic [7:0] d;
    @(negedge clk);
    time_now = 40'h25_03_14_09_30;
    on_batt  = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 no capture after two edges", bat_snap, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 capture on third edge", bat_snap, 40'h25_03_14_09_30);
    chk("R7 bat_valid set", {39'd0, bat_valid}, 40'd1);
    chk("R2 main untouched", main_snap, '0);
    set_power(1'b0, 40'h25_03_14_11_45);
    chk("R2 to-main capture", main_snap, 40'h25_03_14_11_45);
    chk("R7 main_valid set", {39'd0, main_valid}, 40'd1);
    reg_rd(4'd7, d);
    chk("R10 read main byte 2", {32'd0, d}, 40'h14);
    reg_rd(4'd0, d);
    chk("R10 read bat byte 0", {32'd0, d}, 40'h30);
  endtask

  task automatic t_retention();
    set_power(1'b1, 40'h25_04_01_00_05);
    chk("R3 bat keeps first", bat_snap, 40'h25_03_14_09_30);
    set_power(1'b0, 40'h25_04_01_02_10);
    chk("R4 main overwritten", main_snap, 40'h25_04_01_02_10);
    @(negedge clk);
    time_now = 40'h25_04_01_02_59;
    repeat (10) @(negedge clk);
    chk("R8 steady level no capture", main_snap, 40'h25_04_01_02_10);
  endtask

  task automatic t_byte_clear();
    reg_wr(4'd0, 8'h55);
    chk("R5 nonzero write ignored", bat_snap, 40'h25_03_14_09_30);
    for (int i = 0; i < 4; i++) reg_wr(4'(i), 8'h00);
    chk("R5 partial byte clear", bat_snap, 40'h25_00_00_00_00);
    chk("R7 partial bank still valid", {39'd0, bat_valid}, 40'd1);
    set_power(1'b1, 40'h26_01_01_00_00);
    chk("R7 partial bank blocks capture", bat_snap, 40'h25_00_00_00_00);
    set_power(1'b0, 40'h26_01_01_03_00);
    reg_wr(4'd4, 8'h00);
    chk("R5 last byte cleared", bat_snap, '0);
    chk("R7 bat_valid low when empty", {39'd0, bat_valid}, '0);
    reg_wr(4'd9, 8'h00);
    chk("R5 main top byte clear", main_snap, 40'h00_01_01_03_00);
    set_power(1'b1, 40'h26_02_02_04_00);
    chk("R7 empty bank captures", bat_snap, 40'h26_02_02_04_00);
  endtask

  task automatic t_ctrl_clear();
    logic [7:0] d;
    reg_wr(4'd10, 8'h01);
    chk("R6 bank clear bit", bat_snap, '0);
    chk("R6 main unaffected", main_snap, 40'h00_01_01_03_00);
    reg_rd(4'd10, d);
    chk("R10 ctrl reads zero", {32'd0, d}, '0);
    reg_rd(4'd13, d);
    chk("R10 unused reads zero", {32'd0, d}, '0);
  endtask

  task automatic t_race();
    // currently on battery; return to main with a same-cycle clear of byte 5
    @(negedge clk);
    time_now = 40'h27_07_07_07_07;
    on_batt  = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h00;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 capture beats byte clear", main_snap, 40'h27_07_07_07_07);
    // to-battery event into empty bank together with bank clear bit
    @(negedge clk);
    time_now = 40'h27_08_08_08_08;
    on_batt  = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd10; wr_data = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 capture beats bank clear", bat_snap, 40'h27_08_08_08_08);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_capture();
    t_retention();
    t_byte_clear();
    t_ctrl_clear();
    t_race();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule